// File: doc/BRIEF.md
# Register Remap Key-Value Decoder

This block holds a small sparse table of configuration entries. Each entry marks one architectural register as a vector and gives it a new meaning: the physical start register actually used, an element width, and packed-SIMD and bank attributes. An entry applies to the integer register file or to the floating-point file, chosen by a type bit. The block expands the sparse entries into two dense per-register decoded tables of 32 slots each, one for integer and one for FP. A combinational lookup port reads them, giving the register stage the remapped attributes of any register in the same cycle.

Any write to an entry starts a full re-decode. The re-decode rebuilds both tables from scratch by walking the entries from index 0 up to index 15, one entry per cycle. Because a later entry overwrites a slot written by an earlier one, entries may overlap on purpose. A busy flag covers the rebuild. Software waits for it to fall before the lookup results are valid.

Top module: `remap_kv_table`

## Requirements
- R1: After reset, busy is low and every lookup of either type returns a scalar slot: start equal to the looked-up register, width code 0, and the vector, packed and bank flags at 0.
- R2: Entry bit [0] selects the table: 1 updates only the FP table, 0 updates only the integer table. The other table's slot with the same register number keeps its value.
- R3: Entry bits [5:1] name the architectural register (the slot). Bits [10:6] give the start register that a lookup of that slot returns.
- R4: Entry bits [12:11] are the element width code. 0 means default, 1 means half of default, 2 means 8 bits and 3 means 16 bits. The code is returned unchanged by the lookup.
- R5: Entry bit [13] is the is-vector flag, bit [14] the packed-SIMD flag and bit [15] the bank flag. Each is returned unchanged, including the reserved bank value 1.
- R6: Entries are applied in index order 0 to 15. When two entries have the same type and key, the one with the higher index decides the slot.
- R7: A re-decode starts from scalar slots. A slot that no entry names after the rebuild returns the scalar default, even if an earlier decode had remapped it.
- R8: A write at a clock edge raises busy after that edge. Busy stays high for exactly 16 cycles, and the decoded tables are final when it falls.
- R9: A write while busy is high restarts the rebuild. Busy then stays high for 16 cycles counted from the last write.
- R10: The lookup outputs follow the lookup type and register inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one entry |
| cfg_idx | input | 4 | Entry index to write |
| cfg_wdata | input | 16 | Entry value, fields as in R2 to R5 |
| busy | output | 1 | High while the tables are being rebuilt |
| lk_fp | input | 1 | Lookup type: 1 means FP table, 0 means integer table |
| lk_reg | input | 5 | Architectural register to look up |
| lk_start | output | 5 | Remapped start register |
| lk_width | output | 2 | Element width code |
| lk_vec | output | 1 | Is-vector flag |
| lk_packed | output | 1 | Packed-SIMD flag |
| lk_bank | output | 1 | Bank flag |

## Verification
The bench sets up an integer entry and an FP entry with the same key. A design that ignored the type bit would leak one into the other table. It makes a higher-index entry collide with a lower one, so that a design walking entries in the wrong order would keep the wrong winner. It also moves an entry to a new key, so that a design that skipped the clear would leave the old slot remapped. Finally, it writes again in the middle of a rebuild and measures how long busy stays high. A sequencer that ignored the restart would drop busy too early, or would finish from a stale position.

// File: rtl/remap_pkg.sv
// Shared constants, entry layout and decoded slot layout for the register
// remap key-value decoder. Assumes 16 entries and 32 registers per file.
package remap_pkg;
    localparam int NUM_ENTRIES = 16;
    localparam int NUM_REGS    = 32;
    localparam int REG_W       = $clog2(NUM_REGS);
    localparam int IDX_W       = $clog2(NUM_ENTRIES);
    localparam int WID_W       = 2;
    localparam int ENTRY_W     = 1 + REG_W + REG_W + WID_W + 3;

    // Width codes
    localparam logic [WID_W-1:0] WID_DEFAULT = 2'd0;
    localparam logic [WID_W-1:0] WID_HALF    = 2'd1;
    localparam logic [WID_W-1:0] WID_BYTE    = 2'd2;
    localparam logic [WID_W-1:0] WID_HWORD   = 2'd3;

    // Entry word: bank[15] pk[14] is_vec[13] width[12:11] start[10:6] key[5:1] is_fp[0]
    typedef struct packed {
        logic             bank;
        logic             pk;
        logic             is_vec;
        logic [WID_W-1:0] width;
        logic [REG_W-1:0] start;
        logic [REG_W-1:0] key;
        logic             is_fp;
    } entry_t;

    typedef struct packed {
        logic             bank;
        logic             pk;
        logic             is_vec;
        logic [WID_W-1:0] width;
        logic [REG_W-1:0] start;
    } slot_t;

    // Scalar slot for register r
    function automatic slot_t scalar_slot(input logic [REG_W-1:0] r);
        slot_t s;
        s.bank   = 1'b0;
        s.pk     = 1'b0;
        s.is_vec = 1'b0;
        s.width  = WID_DEFAULT;
        s.start  = r;
        return s;
    endfunction

    // Decoded slot carried by an entry
    function automatic slot_t entry_slot(input entry_t e);
        slot_t s;
        s.bank   = e.bank;
        s.pk     = e.pk;
        s.is_vec = e.is_vec;
        s.width  = e.width;
        s.start  = e.start;
        return s;
    endfunction
endpackage

// File: rtl/remap_entry_store.sv
// Holds the sparse configuration entries. Writes land at the clock edge;
// the read port is combinational. Assumes one write per cycle at most.
module remap_entry_store
    import remap_pkg::*;
#(
    parameter int N = NUM_ENTRIES,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] wr_idx,
    input  entry_t        wr_entry,
    input  logic [IW-1:0] rd_idx,
    output entry_t        rd_entry
);
    entry_t entries [N];

    // Store written entries; reset clears every entry to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) entries[i] <= '0;
        end else if (we) begin
            entries[wr_idx] <= wr_entry;
        end
    end

    // Read the entry the sequencer is applying
    assign rd_entry = entries[rd_idx];

    // R6: a written entry is held for the ordered walk
    a_r6_entry_stored: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> entries[$past(wr_idx)] == $past(wr_entry));
endmodule

// File: rtl/remap_sequencer.sv
// Walks the entries in index order after each write, one per cycle, and
// raises busy for the whole walk. A write restarts the walk at index 0.
module remap_sequencer
    import remap_pkg::*;
#(
    parameter int N = NUM_ENTRIES,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    output logic          busy,
    output logic [IW-1:0] step,
    output logic          apply_valid,
    output logic          apply_first
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    // Step counter and busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            step <= '0;
        end else if (we) begin
            busy <= 1'b1;
            step <= '0;
        end else if (busy) begin
            step <= step + 1'b1;
            if (step == LAST) busy <= 1'b0;
        end
    end

    // An entry is applied on every busy cycle that carries no new write
    assign apply_valid = busy && !we;
    assign apply_first = (step == '0);

    // R8: a write always starts a fresh walk
    a_r8_write_starts: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> busy && step == '0);
    // R8: the walk ends after the last entry
    a_r8_walk_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !we && step == LAST) |=> !busy);
    // R9: busy never falls in the middle of a walk
    a_r9_no_early_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step != LAST) |=> busy);
    // R8: idle stays idle without a write
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !we) |=> !busy);
endmodule

// File: rtl/remap_decoded_table.sv
// One dense decoded table (integer or FP, chosen by IS_FP). The first
// applied step rebuilds every slot from the scalar default, then
// overlays the entry; later steps overlay onto the current contents.
// The lookup read is combinational.
module remap_decoded_table
    import remap_pkg::*;
#(
    parameter bit IS_FP = 1'b0,
    parameter int R     = NUM_REGS,
    localparam int RW   = $clog2(R)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          apply_valid,
    input  logic          apply_first,
    input  entry_t        apply_entry,
    input  logic [RW-1:0] lk_reg,
    output slot_t         lk_slot
);
    slot_t slots [R];
    logic  hit;

    assign hit = (apply_entry.is_fp == IS_FP);

    // Rebuild or overlay slots during the walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < R; i++) slots[i] <= scalar_slot(RW'(i));
        end else if (apply_valid) begin
            for (int i = 0; i < R; i++) begin
                if (hit && apply_entry.key == RW'(i))
                    slots[i] <= entry_slot(apply_entry);
                else if (apply_first)
                    slots[i] <= scalar_slot(RW'(i));
            end
        end
    end

    // Combinational lookup
    assign lk_slot = slots[lk_reg];

    // R3: a matching entry lands in the slot its key names
    a_r3_key_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_valid && hit) |=> slots[$past(apply_entry.key)] == $past(entry_slot(apply_entry)));
    // R2: an entry of the other type leaves this table's slot alone
    a_r2_other_type_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_valid && !hit && !apply_first)
            |=> slots[$past(apply_entry.key)] == $past(slots[apply_entry.key]));
    // R7: the first step clears a slot that the entry does not name
    a_r7_first_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_valid && apply_first && !(hit && apply_entry.key == lk_reg))
            |=> slots[$past(lk_reg)] == scalar_slot($past(lk_reg)));
endmodule

// File: rtl/remap_kv_table.sv
// Top of the register remap key-value decoder: entry store, ordered
// sequencer, one decoded table per register file type, and a lookup mux.
// Assumes software waits for busy low before trusting the lookup.
module remap_kv_table
    import remap_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [ENTRY_W-1:0]     cfg_wdata,
    output logic                   busy,
    input  logic                   lk_fp,
    input  logic [REG_W-1:0]       lk_reg,
    output logic [REG_W-1:0]       lk_start,
    output logic [WID_W-1:0]       lk_width,
    output logic                   lk_vec,
    output logic                   lk_packed,
    output logic                   lk_bank
);
    localparam int NUM_TYPES = 2;

    entry_t           cur_entry;
    logic [IDX_W-1:0] step;
    logic             apply_valid;
    logic             apply_first;
    slot_t            type_slot [NUM_TYPES];
    slot_t            sel;

    remap_entry_store #(.N(NUM_ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wr_idx(cfg_idx),
        .wr_entry(entry_t'(cfg_wdata)), .rd_idx(step), .rd_entry(cur_entry)
    );

    remap_sequencer #(.N(NUM_ENTRIES)) u_seq (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .busy(busy), .step(step),
        .apply_valid(apply_valid), .apply_first(apply_first)
    );

    // One decoded table per register file type
    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
        remap_decoded_table #(.IS_FP(t[0]), .R(NUM_REGS)) u_tbl (
            .clk(clk), .rst_n(rst_n), .apply_valid(apply_valid),
            .apply_first(apply_first), .apply_entry(cur_entry),
            .lk_reg(lk_reg), .lk_slot(type_slot[t])
        );
    end

    // Select the table for the requested type
    assign sel       = type_slot[lk_fp];
    assign lk_start  = sel.start;
    assign lk_width  = sel.width;
    assign lk_vec    = sel.is_vec;
    assign lk_packed = sel.pk;
    assign lk_bank   = sel.bank;

    // R1: leaving reset, the lookup is scalar and busy is low
    a_r1_reset_scalar: assert property (@(posedge clk)
        !rst_n |=> !busy && lk_start == $past(lk_reg) && lk_width == WID_DEFAULT
                   && !lk_vec && !lk_packed && !lk_bank);
endmodule

// File: tb/tb_remap_kv_table.sv
`timescale 1ns/1ps
// Bench: behavioural reference (entry array searched last-match-wins,
// busy countdown) compared every clock and over full lookup sweeps.
module tb_remap_kv_table;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_idx = '0;
    logic [15:0] cfg_wdata = '0;
    logic       busy;
    logic       lk_fp = 1'b0;
    logic [4:0] lk_reg = '0;
    logic [4:0] lk_start;
    logic [1:0] lk_width;
    logic       lk_vec, lk_packed, lk_bank;

    int checks = 0;
    int errors = 0;
    int busy_left = 0;
    logic [15:0] ref_ent [16];

    always #4 clk = ~clk;

    remap_kv_table dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .busy(busy), .lk_fp(lk_fp), .lk_reg(lk_reg),
        .lk_start(lk_start), .lk_width(lk_width), .lk_vec(lk_vec),
        .lk_packed(lk_packed), .lk_bank(lk_bank)
    );

    // Reference busy countdown, updated at each edge
    always @(posedge clk) begin
        if (!rst_n) busy_left <= 0;
        else if (cfg_we) busy_left <= 16;
        else if (busy_left > 0) busy_left <= busy_left - 1;
    end

    // Busy compared every cycle (R8, R9)
    always @(negedge clk) begin
        checks++;
        if (busy !== (busy_left > 0)) begin
            errors++;
            $display("FAIL R8 busy: actual %0b expected %0b", busy, busy_left > 0);
        end
    end

    // Reference lookup: {bank,pk,vec,width,start}
    function automatic logic [9:0] ref_lookup(input logic fp, input logic [4:0] r);
        logic [9:0] res;
        res = {5'b0, r};
        for (int i = 0; i < 16; i++)
            if (ref_ent[i][0] == fp && ref_ent[i][5:1] == r)
                res = ref_ent[i][15:6];
        return res;
    endfunction

    function automatic logic [15:0] mk(input logic fp, input logic [4:0] key,
        input logic [4:0] st, input logic [1:0] w, input logic v, input logic p, input logic b);
        return {b, p, v, w, st, key, fp};
    endfunction

    task automatic write_entry(input logic [3:0] idx, input logic [15:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
        ref_ent[idx] = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic check_one(input string tag, input logic fp, input logic [4:0] r);
        logic [9:0] act, exp;
        lk_fp = fp; lk_reg = r;
        #1;
        act = {lk_bank, lk_packed, lk_vec, lk_width, lk_start};
        exp = ref_lookup(fp, r);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s lookup fp=%0b reg=%0d: actual %h expected %h", tag, fp, r, act, exp);
        end
    endtask

    task automatic sweep(input string tag);
        for (int f = 0; f < 2; f++)
            for (int r = 0; r < 32; r++) begin
                @(negedge clk);
                check_one(tag, f[0], r[4:0]);
            end
    endtask

    task automatic measure_busy(input string tag);
        int n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
        checks++;
        if (n != 16) begin
            errors++;
            $display("FAIL %s busy length: actual %0d expected 16", tag, n);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) ref_ent[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        sweep("R1");
        // R3, R4, R8: integer key 5 to start 12, 8-bit elements
        write_entry(4'd0, mk(1'b0, 5'd5, 5'd12, 2'd2, 1'b1, 1'b0, 1'b0));
        measure_busy("R8");
        sweep("R3");
        // R2, R5: FP entry on the same key, half width, packed, reserved bank
        write_entry(4'd1, mk(1'b1, 5'd5, 5'd20, 2'd1, 1'b0, 1'b1, 1'b1));
        wait_idle();
        sweep("R2");
        // R4: 16-bit code on another register
        write_entry(4'd4, mk(1'b1, 5'd31, 5'd0, 2'd3, 1'b1, 1'b1, 1'b0));
        wait_idle();
        @(negedge clk); check_one("R4", 1'b1, 5'd31);
        @(negedge clk); check_one("R5", 1'b1, 5'd5);
        // R6: higher index wins on integer key 5
        write_entry(4'd7, mk(1'b0, 5'd5, 5'd3, 2'd3, 1'b0, 1'b1, 1'b0));
        wait_idle();
        @(negedge clk); check_one("R6", 1'b0, 5'd5);
        // R7: entry 2 maps key 9, then moves to key 10
        write_entry(4'd2, mk(1'b0, 5'd9, 5'd17, 2'd2, 1'b1, 1'b0, 1'b0));
        wait_idle();
        @(negedge clk); check_one("R7", 1'b0, 5'd9);
        write_entry(4'd2, mk(1'b0, 5'd10, 5'd18, 2'd0, 1'b1, 1'b0, 1'b0));
        wait_idle();
        sweep("R7");
        // R9: rewrite in the middle of a walk
        write_entry(4'd15, mk(1'b0, 5'd10, 5'd1, 2'd1, 1'b1, 1'b1, 1'b1));
        repeat (5) @(negedge clk);
        write_entry(4'd3, mk(1'b1, 5'd0, 5'd7, 2'd2, 1'b1, 1'b0, 1'b0));
        measure_busy("R9");
        sweep("R9");
        // R10: lookup follows inputs without a clock edge
        @(negedge clk);
        check_one("R10", 1'b0, 5'd10);
        check_one("R10", 1'b1, 5'd0);
        check_one("R10", 1'b0, 5'd11);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule